// File: doc/BRIEF.md
# Depth-Selectable Pixel Unpacker and Serializer

This block turns one fetched display byte into a run of coloured pixels. A depth code chooses how many bits make up one pixel: eight one-bit pixels, four two-bit pixels or two four-bit pixels. Multi-bit pixels are not stored as contiguous bit fields. Their bits are interleaved across the two nibbles of the byte, and this block undoes that packing.

Each pixel's colour index selects an entry of an 8-entry palette of 3-bit RGB values. The pixel is then held on the output for a programmable number of clocks, which stretches it horizontally. A fetch engine offers a byte with a valid strobe. The block accepts the byte only while it is idle, then reports busy until the last pixel has completed its hold count.

A blanking input forces the output to black and freezes the serializer. This is used during gaps between character rows. The depth and the hold count are captured together with the byte, so they can change freely while a byte is being shifted out.

Top module: `pix_serializer`

## Requirements
- R1: After reset `rgb_o` is 0, `busy_o` is 0, and palette entry i holds the value i (identity mapping).
- R2: With depth code 0 (1 bit per pixel) a byte gives 8 pixels, in order from bit 7 down to bit 0. The colour index of each pixel is that single bit.
- R3: With depth code 1 (2 bits per pixel) a byte gives 4 pixels. Pixel k (k = 0..3) has colour index {bit (7-k), bit (3-k)}, with the first bit as the high bit.
- R4: With depth code 2 or 3 (4 bits per pixel) a byte gives 2 pixels. Pixel k (k = 0..1) has colour bits 3..0 taken from byte bits (7-k), (5-k), (3-k), (1-k). Colour bit 3 is discarded before the palette lookup.
- R5: While busy and not blanked, `rgb_o` equals the palette entry addressed by the current pixel's 3-bit index. Within that value, bit 0 is red, bit 1 is green and bit 2 is blue.
- R6: Each pixel stays on the output for `scale_i` unblanked clocks, as captured at load time. A captured value of 0 behaves as 1.
- R7: A byte is loaded on a clock edge only when `busy_o` is 0 and `byte_valid_i` is 1. The byte appears from the following cycle. A strobe, byte, depth or scale change while busy has no effect on the pixels being shifted out.
- R8: `busy_o` clears after the last pixel has completed its hold count. While it is 0, `rgb_o` is 0.
- R9: While `blank_i` is 1, `rgb_o` is 0 and the pixel position and hold count do not advance.
- R10: A palette write (`pal_we_i`) stores `pal_val_i` into entry `pal_idx_i` on the clock edge. The new value is used from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byte_i | input | 8 | Fetched display byte |
| byte_valid_i | input | 1 | Byte offered for loading |
| depth_i | input | 2 | Depth code: 0 = 1 bpp, 1 = 2 bpp, 2 or 3 = 4 bpp |
| scale_i | input | SCALE_W | Clocks per pixel (0 treated as 1) |
| blank_i | input | 1 | Force black and pause shifting |
| pal_we_i | input | 1 | Palette write enable |
| pal_idx_i | input | 3 | Palette entry to write |
| pal_val_i | input | 3 | RGB value to write |
| rgb_o | output | 3 | Pixel colour {blue, green, red} |
| busy_o | output | 1 | Pixels remain to be shown |

## Verification
The bench uses the default SCALE_W of 3. Hold counts therefore run from 0 through 7. This covers the 1, 2 and 4 that display modes need, the 0-as-1 corner, and odd values that expose off-by-one faults in the hold counter. Random bytes go through all four depth codes, including the duplicate 4-bit code. Blanking is inserted at random points in a run to check the freeze, and some runs start from a rewritten palette, which shows whether the interleaved index bits reach the right entries.

// File: rtl/pix_ser_pkg.sv
package pix_ser_pkg;
    localparam int BYTE_W = 8;
    localparam int PAL_N  = 8;
    localparam int PAL_AW = $clog2(PAL_N);
    localparam int RGB_W  = 3;

    typedef enum logic [1:0] {
        DEPTH_1  = 2'd0,
        DEPTH_2  = 2'd1,
        DEPTH_4  = 2'd2,
        DEPTH_4B = 2'd3
    } depth_e;

    // pixels contained in one byte for a depth code
    function automatic logic [3:0] pix_count(input logic [1:0] d);
        case (d)
            DEPTH_1: pix_count = 4'd8;
            DEPTH_2: pix_count = 4'd4;
            default: pix_count = 4'd2;
        endcase
    endfunction
endpackage

// File: rtl/pix_unpack.sv
module pix_unpack
    import pix_ser_pkg::*;
(
    input  logic [BYTE_W-1:0] data_i,
    input  logic [1:0]        depth_i,
    input  logic [2:0]        pos_i,
    output logic [PAL_AW-1:0] index_o
);
    logic [PAL_AW-1:0] one_bpp  [8];
    logic [PAL_AW-1:0] two_bpp  [4];
    logic [PAL_AW-1:0] four_bpp [2];

    // one lane per pixel position; 4 bpp colour bit 3 is dropped here
    for (genvar k = 0; k < 8; k++) begin : g_one
        assign one_bpp[k] = {2'b00, data_i[7-k]};
    end
    for (genvar k = 0; k < 4; k++) begin : g_two
        assign two_bpp[k] = {1'b0, data_i[7-k], data_i[3-k]};
    end
    for (genvar k = 0; k < 2; k++) begin : g_four
        assign four_bpp[k] = {data_i[5-k], data_i[3-k], data_i[1-k]};
    end

    always_comb begin
        case (depth_i)
            DEPTH_1: index_o = one_bpp[pos_i];
            DEPTH_2: index_o = two_bpp[pos_i[1:0]];
            default: index_o = four_bpp[pos_i[0]];
        endcase
    end
endmodule

// File: rtl/pix_palette.sv
module pix_palette
    import pix_ser_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [PAL_AW-1:0] widx_i,
    input  logic [RGB_W-1:0]  wval_i,
    input  logic [PAL_AW-1:0] ridx_i,
    output logic [RGB_W-1:0]  rval_o
);
    logic [RGB_W-1:0] pal_q [PAL_N];
    logic [RGB_W-1:0] pal_d [PAL_N];

    always_comb begin
        for (int i = 0; i < PAL_N; i++) begin
            pal_d[i] = pal_q[i];
        end
        if (we_i) begin
            pal_d[widx_i] = wval_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < PAL_N; i++) begin
                pal_q[i] <= RGB_W'(i);
            end
        end else begin
            for (int i = 0; i < PAL_N; i++) begin
                pal_q[i] <= pal_d[i];
            end
        end
    end

    assign rval_o = pal_q[ridx_i];

    // R10: a written value is present in its entry one cycle later
    a_r10_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (pal_q[$past(widx_i)] == $past(wval_i)));
endmodule

// File: rtl/pix_serializer.sv
module pix_serializer
    import pix_ser_pkg::*;
#(
    parameter int SCALE_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [7:0]         byte_i,
    input  logic               byte_valid_i,
    input  logic [1:0]         depth_i,
    input  logic [SCALE_W-1:0] scale_i,
    input  logic               blank_i,
    input  logic               pal_we_i,
    input  logic [2:0]         pal_idx_i,
    input  logic [2:0]         pal_val_i,
    output logic [2:0]         rgb_o,
    output logic               busy_o
);
    localparam logic [SCALE_W-1:0] ONE = SCALE_W'(1);

    typedef struct packed {
        logic               busy;
        logic [7:0]         data;
        logic [1:0]         depth;
        logic [SCALE_W-1:0] scale;
        logic [2:0]         pos;
        logic [SCALE_W-1:0] cnt;
    } state_t;

    state_t st_d, st_q;
    logic [PAL_AW-1:0] index_w;
    logic [RGB_W-1:0]  colour_w;
    logic              last_pos_w;

    pix_unpack u_unpack (
        .data_i  (st_q.data),
        .depth_i (st_q.depth),
        .pos_i   (st_q.pos),
        .index_o (index_w)
    );

    pix_palette u_palette (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (pal_we_i),
        .widx_i (pal_idx_i),
        .wval_i (pal_val_i),
        .ridx_i (index_w),
        .rval_o (colour_w)
    );

    assign last_pos_w = ({1'b0, st_q.pos} == (pix_count(st_q.depth) - 4'd1));

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (byte_valid_i) begin
                st_d.busy  = 1'b1;
                st_d.data  = byte_i;
                st_d.depth = depth_i;
                st_d.scale = (scale_i == '0) ? ONE : scale_i;
                st_d.pos   = 3'd0;
                st_d.cnt   = (scale_i == '0) ? ONE : scale_i;
            end
        end else if (!blank_i) begin
            if (st_q.cnt <= ONE) begin
                st_d.cnt = st_q.scale;
                if (last_pos_w) begin
                    st_d.busy = 1'b0;
                end else begin
                    st_d.pos = st_q.pos + 3'd1;
                end
            end else begin
                st_d.cnt = st_q.cnt - ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rgb_o  = (st_q.busy && !blank_i) ? colour_w : 3'b000;
    assign busy_o = st_q.busy;

    // R7: a run only starts after an offered byte
    a_r7_load_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.busy) |-> $past(byte_valid_i));
    // R7: the held byte never changes during a run
    a_r7_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |=> $stable(st_q.data));
    // R9: blanking freezes position and hold count
    a_r9_blank_pause: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && blank_i) |=> ($stable(st_q.pos) && $stable(st_q.cnt)));
    // R6: position holds until the count expires
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !blank_i && st_q.cnt > ONE) |=> $stable(st_q.pos));
    // R2 R3 R4: position stays inside the byte's pixel count
    a_r4_pos_range: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> ({1'b0, st_q.pos} < pix_count(st_q.depth)));
endmodule

// File: tb/pix_serializer_bench.sv
module pix_serializer_bench;
    localparam int SW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    byte_i = '0;
    logic          byte_valid_i = 1'b0;
    logic [1:0]    depth_i = '0;
    logic [SW-1:0] scale_i = '0;
    logic          blank_i = 1'b0;
    logic          pal_we_i = 1'b0;
    logic [2:0]    pal_idx_i = '0;
    logic [2:0]    pal_val_i = '0;
    logic [2:0]    rgb_o;
    logic          busy_o;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;
    logic [2:0] pal_m [8];

    always #2 clk = ~clk;

    pix_serializer #(.SCALE_W(SW)) u_pix_serializer (
        .clk(clk), .rst_n(rst_n), .byte_i(byte_i), .byte_valid_i(byte_valid_i),
        .depth_i(depth_i), .scale_i(scale_i), .blank_i(blank_i),
        .pal_we_i(pal_we_i), .pal_idx_i(pal_idx_i), .pal_val_i(pal_val_i),
        .rgb_o(rgb_o), .busy_o(busy_o)
    );

    function automatic int npix(input int d);
        return (d == 0) ? 8 : (d == 1) ? 4 : 2;
    endfunction

    // reference packing per R2/R3/R4 (4 bpp colour bit 3 dropped)
    function automatic int ref_index(input logic [7:0] b, input int d, input int k);
        if (d == 0) return int'(b[7-k]);
        if (d == 1) return int'({b[7-k], b[3-k]});
        return int'({b[5-k], b[3-k], b[1-k]});
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    endtask

    task automatic pal_write(input int i, input int v);
        @(negedge clk);
        pal_we_i = 1'b1; pal_idx_i = 3'(i); pal_val_i = 3'(v);
        @(negedge clk);
        pal_we_i = 1'b0;
        pal_m[i] = 3'(v);
    endtask

    // one byte end to end; blank_pct: chance of blanking per cycle
    task automatic run_byte(input logic [7:0] b, input int d, input int s,
                            input int blank_pct, input bit junk);
        int eff = (s == 0) ? 1 : s;
        int k = 0;
        int c = 0;
        @(negedge clk);
        byte_i = b; depth_i = 2'(d); scale_i = SW'(s); byte_valid_i = 1'b1; blank_i = 1'b0;
        while (k < npix(d)) begin
            @(negedge clk);
            // R7: inputs while busy are junk unless idle
            byte_valid_i = junk;
            byte_i = 8'($urandom); depth_i = 2'($urandom); scale_i = SW'($urandom);
            blank_i = (int'($urandom_range(99)) < blank_pct);
            #1;
            check("R8 busy during run", int'(busy_o), 1);
            if (blank_i) begin
                check("R9 blank black", int'(rgb_o), 0);
            end else begin
                // R2 R3 R4 R5 R6
                check($sformatf("R5 depth%0d pix%0d", d, k), int'(rgb_o),
                      int'(pal_m[ref_index(b, d, k)]));
                c++;
                if (c == eff) begin c = 0; k++; end
            end
        end
        @(negedge clk);
        byte_valid_i = 1'b0; blank_i = 1'b0;
        #1;
        check("R8 busy clears", int'(busy_o), 0);
        check("R8 idle black", int'(rgb_o), 0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 8; i++) pal_m[i] = 3'(i);
        #1;
        check("R1 rgb reset", int'(rgb_o), 0);
        check("R1 busy reset", int'(busy_o), 0);
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        check("R1 busy after reset", int'(busy_o), 0);

        // directed corners, identity palette (R1)
        run_byte(8'hA5, 0, 1, 0, 0);   // R2
        run_byte(8'h9C, 1, 2, 0, 0);   // R3
        run_byte(8'hFF, 2, 4, 0, 0);   // R4 bit 3 dropped
        run_byte(8'h6B, 3, 3, 0, 0);   // R4 duplicate code
        run_byte(8'h3C, 0, 0, 0, 0);   // R6 zero as one
        run_byte(8'hC3, 1, 7, 0, 1);   // R7 junk while busy
        run_byte(8'h5A, 2, 2, 40, 1);  // R9 blanking

        // R10 palette rewrite then check through pixels
        pal_write(0, 5); pal_write(1, 2); pal_write(3, 6); pal_write(7, 1);
        run_byte(8'hF0, 1, 1, 0, 0);
        run_byte(8'h81, 0, 2, 0, 0);

        for (int r = 0; r < 60; r++) begin
            if (r % 10 == 5) pal_write(int'($urandom_range(7)), int'($urandom_range(7)));
            run_byte(8'($urandom), int'($urandom_range(3)), int'($urandom_range(7)),
                     (r % 3 == 0) ? 30 : 0, 1'($urandom));
        end
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end
endmodule